// File: doc/BRIEF.md
# Tape Reader I/O Controller

This block sits on the programmed-I/O bus of a 12-bit minicomputer and serves an 8-bit character tape reader. Each I/O operation arrives with a 3-bit operation code taken from the low bits of the instruction and the current accumulator value. The block answers in the same cycle. It returns the accumulator, possibly merged with the reader buffer, drives a skip line and flags codes that it does not define.

The controller holds an 8-bit character buffer, a done flag, a reader interrupt enable and a record of whether a character fetch is outstanding. A fetch starts with a one-cycle request to a character source. When the source returns a character while that fetch is outstanding, the low 8 bits are stored and done is set. The interrupt request is the done flag gated by the enable. The enable-setting code also pulses an output so that the neighbouring punch controller can set its own enable. An input from that punch lets its enable-clear operation clear the reader enable as well.

Top module: `tape_rdr_ctrl`

## Requirements
- R1: Code 0 (binary 000) sets the reader interrupt enable from the next cycle, raises `punch_ie_set` in the same cycle, and returns `acc_in` unchanged on `acc_out`.
- R2: Code 1 (001) drives `skip` high in the same cycle exactly when the done flag is set. It changes no state and returns `acc_in` unchanged.
- R3: Code 2 (010) returns `acc_in` ORed with the zero-extended 8-bit buffer in the same cycle. From the next cycle it clears done, so `irq` is low, and it starts no fetch.
- R4: Code 4 (100) returns `acc_in` unchanged. It clears done from the next cycle and raises `fetch_req` for exactly the one cycle after the operation.
- R5: Code 6 (110) returns `acc_in` ORed with the buffer, clears done and raises `fetch_req` for one cycle, all as the result of a single operation.
- R6: A `chr_valid` while a fetch is outstanding stores bits 7..0 of `chr_data`, sets done from the next cycle and ends the fetch. When it coincides with a clearing operation, the arrival wins and done ends up set.
- R7: A `chr_valid` while no fetch is outstanding is ignored: both the buffer and the done flag keep their values.
- R8: `irq` equals done AND the reader enable, taken from registered state. `punch_ie_clr` clears the enable. If code 0 arrives in the same cycle, the set wins.
- R9: Active-low synchronous reset clears the buffer and done, sets the reader enable and cancels any outstanding fetch.
- R10: Codes 3, 5 and 7 (011, 101, 111) raise `illegal` in the same cycle, return `acc_in` unchanged and change no state.
- R11: While `iop_valid` is low no code is decoded: `acc_out` equals `acc_in`, and `skip`, `illegal` and `punch_ie_set` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iop_valid | input | 1 | An I/O operation addressed to the reader is present this cycle |
| iop_code | input | 3 | Operation code from the low instruction bits |
| acc_in | input | 12 | Accumulator value presented with the operation |
| acc_out | output | 12 | Accumulator value returned to the processor |
| skip | output | 1 | Skip request for the processor |
| illegal | output | 1 | Undefined operation code seen |
| punch_ie_set | output | 1 | Asks the punch controller to set its interrupt enable |
| punch_ie_clr | input | 1 | Enable-clear pulse coming from the punch controller |
| fetch_req | output | 1 | One-cycle request to the character source |
| chr_valid | input | 1 | Character from the source is valid this cycle |
| chr_data | input | 12 | Character from the source; only bits 7..0 are kept |
| irq | output | 1 | Reader interrupt request |

## Verification
The bench builds the block with its defaults: a 12-bit accumulator and character input and an 8-bit buffer. With these widths every character carries upper bits that must be dropped, and every buffer merge leaves accumulator bits above the buffer that must survive the OR. Defaults also keep every code value reachable, so the three undefined codes and both combined read-and-fetch paths are driven directly. The width difference lets a test tell a cleared accumulator apart from an OR merge.

// File: rtl/tape_rdr_pkg.sv
// Shared definitions for the tape reader controller.
// Assumes a 3-bit operation code; code values are fixed by the bus.
package tape_rdr_pkg;

    localparam int CODE_W = 3;

    localparam logic [CODE_W-1:0] OPC_IE_SET     = 3'd0;
    localparam logic [CODE_W-1:0] OPC_FLAG_TEST  = 3'd1;
    localparam logic [CODE_W-1:0] OPC_READ       = 3'd2;
    localparam logic [CODE_W-1:0] OPC_FETCH      = 3'd4;
    localparam logic [CODE_W-1:0] OPC_READ_FETCH = 3'd6;

    // Actions one operation may request; several may be set together.
    typedef struct packed {
        logic ie_set;
        logic flag_test;
        logic flag_clr;
        logic buf_read;
        logic fetch_go;
        logic bad_op;
    } rdr_act_t;

endpackage

// File: rtl/tape_rdr_decode.sv
// Operation decoder: turns a valid operation code into a set of actions.
// Assumes the code is meaningful only while op_valid is high.
module tape_rdr_decode
    import tape_rdr_pkg::*;
(
    input  logic              op_valid,
    input  logic [CODE_W-1:0] op_code,
    output rdr_act_t          act
);

    // Map each defined code to its actions, flag everything else.
    always_comb begin
        act = '0;
        if (op_valid) begin
            unique case (op_code)
                OPC_IE_SET:     act.ie_set    = 1'b1;
                OPC_FLAG_TEST:  act.flag_test = 1'b1;
                OPC_READ: begin
                    act.flag_clr = 1'b1;
                    act.buf_read = 1'b1;
                end
                OPC_FETCH: begin
                    act.flag_clr = 1'b1;
                    act.fetch_go = 1'b1;
                end
                OPC_READ_FETCH: begin
                    act.flag_clr = 1'b1;
                    act.buf_read = 1'b1;
                    act.fetch_go = 1'b1;
                end
                default:        act.bad_op    = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/tape_rdr_store.sv
// Character store: buffer, done flag, outstanding-fetch record, fetch pulse.
// Assumes CHR_IN_W >= BUF_W; only the low BUF_W bits of a character are kept.
module tape_rdr_store #(
    parameter int CHR_IN_W = 12,
    parameter int BUF_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flag_clr,
    input  logic                fetch_go,
    input  logic                chr_valid,
    input  logic [CHR_IN_W-1:0] chr_data,
    output logic [BUF_W-1:0]    buf_q,
    output logic                done_q,
    output logic                fetch_req
);

    logic pend_q;
    logic accept;

    // A character counts only while a fetch is outstanding.
    assign accept = chr_valid && pend_q;

    // Track the outstanding fetch and issue its one-cycle request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            fetch_req <= 1'b0;
        end else begin
            fetch_req <= fetch_go;
            if (fetch_go)
                pend_q <= 1'b1;
            else if (accept)
                pend_q <= 1'b0;
        end
    end

    // Latch an accepted character; arrival takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            done_q <= 1'b0;
        end else if (accept) begin
            buf_q  <= chr_data[BUF_W-1:0];
            done_q <= 1'b1;
        end else if (flag_clr) begin
            done_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tape_rdr_irq.sv
// Interrupt gating: holds the reader enable and forms the request.
// Assumes set and clear may coincide; set takes priority.
module tape_rdr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ie_set,
    input  logic ie_clr,
    input  logic done_q,
    output logic irq
);

    logic ie_q;

    // Reader interrupt enable, on after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= 1'b1;
        else if (ie_set)
            ie_q <= 1'b1;
        else if (ie_clr)
            ie_q <= 1'b0;
    end

    // Request follows registered done and enable.
    assign irq = done_q && ie_q;

endmodule

// File: rtl/tape_rdr_ctrl.sv
// Tape reader I/O controller top: decodes bus operations, returns the
// accumulator, drives skip and illegal, and owns the character store and
// interrupt gating. Assumes ACC_W > BUF_W and CHR_IN_W >= BUF_W.
module tape_rdr_ctrl
    import tape_rdr_pkg::*;
#(
    parameter int ACC_W    = 12,
    parameter int CHR_IN_W = 12,
    parameter int BUF_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iop_valid,
    input  logic [CODE_W-1:0]   iop_code,
    input  logic [ACC_W-1:0]    acc_in,
    output logic [ACC_W-1:0]    acc_out,
    output logic                skip,
    output logic                illegal,
    output logic                punch_ie_set,
    input  logic                punch_ie_clr,
    output logic                fetch_req,
    input  logic                chr_valid,
    input  logic [CHR_IN_W-1:0] chr_data,
    output logic                irq
);

    localparam int PAD_W = ACC_W - BUF_W;

    rdr_act_t         act;
    logic [BUF_W-1:0] buf_q;
    logic             done_q;
    logic [ACC_W-1:0] buf_wide;

    tape_rdr_decode u_decode (
        .op_valid (iop_valid),
        .op_code  (iop_code),
        .act      (act)
    );

    tape_rdr_store #(
        .CHR_IN_W (CHR_IN_W),
        .BUF_W    (BUF_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flag_clr  (act.flag_clr),
        .fetch_go  (act.fetch_go),
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .buf_q     (buf_q),
        .done_q    (done_q),
        .fetch_req (fetch_req)
    );

    tape_rdr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ie_set (act.ie_set),
        .ie_clr (punch_ie_clr),
        .done_q (done_q),
        .irq    (irq)
    );

    // Widen the buffer to the accumulator width.
    assign buf_wide = {{PAD_W{1'b0}}, buf_q};

    // Merge the buffer into the returned accumulator on read codes.
    always_comb begin
        acc_out = acc_in;
        if (act.buf_read)
            acc_out = acc_in | buf_wide;
    end

    // Same-cycle bus responses.
    assign skip         = act.flag_test && done_q;
    assign illegal      = act.bad_op;
    assign punch_ie_set = act.ie_set;

endmodule

// File: rtl/tape_rdr_ctrl_chk.sv
// Assertion checker for the tape reader controller, bound to the top.
// Observes ports only.
module tape_rdr_ctrl_chk #(
    parameter int ACC_W    = 12,
    parameter int CHR_IN_W = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                iop_valid,
    input logic [2:0]          iop_code,
    input logic [ACC_W-1:0]    acc_in,
    input logic [ACC_W-1:0]    acc_out,
    input logic                skip,
    input logic                illegal,
    input logic                punch_ie_set,
    input logic                punch_ie_clr,
    input logic                fetch_req,
    input logic                chr_valid,
    input logic [CHR_IN_W-1:0] chr_data,
    input logic                irq
);

    // R4/R5: a fetch request follows a fetching code one cycle earlier.
    a_r4_fetch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> $past(iop_valid && (iop_code == 3'd4 || iop_code == 3'd6)));

    // R2: skip only answers the flag-test code.
    a_r2_skip_source: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (iop_valid && iop_code == 3'd1));

    // R10: an undefined code leaves the accumulator untouched.
    a_r10_illegal_acc: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (acc_out == acc_in));

    // R1: the punch enable pulse leaves the accumulator untouched.
    a_r1_punch_acc: assert property (@(posedge clk) disable iff (!rst_n)
        punch_ie_set |-> (acc_out == acc_in && !skip && !illegal));

    // R3: a read without a coinciding character drops the request.
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (iop_valid && iop_code == 3'd2 && !chr_valid) |=> !irq);

    // R8: the request rises only after a character or an enable set.
    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(chr_valid || (iop_valid && iop_code == 3'd0)));

    // R11: with no operation the bus sees a pure pass-through.
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !iop_valid |-> (acc_out == acc_in && !skip && !illegal && !punch_ie_set));

endmodule

bind tape_rdr_ctrl tape_rdr_ctrl_chk #(
    .ACC_W    (ACC_W),
    .CHR_IN_W (CHR_IN_W)
) u_chk (.*);

// File: tb/tape_rdr_ctrl_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module tape_rdr_ctrl_bench;

    localparam int VEC_W = 46;
    localparam int NVEC  = 14;

    // Row: valid, code, acc_in, chr_valid, chr_data,
    //      exp acc_out, exp skip, exp illegal, exp punch_ie_set,
    //      exp fetch_req after edge, exp irq after edge
    localparam logic [VEC_W-1:0] VECS [NVEC] = '{
        {1'b1,3'd1,12'h123,1'b0,12'h000,12'h123,1'b0,1'b0,1'b0,1'b0,1'b0},
        {1'b1,3'd4,12'h055,1'b0,12'h000,12'h055,1'b0,1'b0,1'b0,1'b1,1'b0},
        {1'b0,3'd0,12'h000,1'b1,12'hFA5,12'h000,1'b0,1'b0,1'b0,1'b0,1'b1},
        {1'b1,3'd1,12'h000,1'b0,12'h000,12'h000,1'b1,1'b0,1'b0,1'b0,1'b1},
        {1'b1,3'd2,12'h300,1'b0,12'h000,12'h3A5,1'b0,1'b0,1'b0,1'b0,1'b0},
        {1'b1,3'd1,12'h000,1'b0,12'h000,12'h000,1'b0,1'b0,1'b0,1'b0,1'b0},
        {1'b1,3'd6,12'h00F,1'b0,12'h000,12'h0AF,1'b0,1'b0,1'b0,1'b1,1'b0},
        {1'b0,3'd0,12'h000,1'b1,12'h03C,12'h000,1'b0,1'b0,1'b0,1'b0,1'b1},
        {1'b1,3'd3,12'h777,1'b0,12'h000,12'h777,1'b0,1'b1,1'b0,1'b0,1'b1},
        {1'b1,3'd5,12'h001,1'b0,12'h000,12'h001,1'b0,1'b1,1'b0,1'b0,1'b1},
        {1'b1,3'd7,12'h000,1'b0,12'h000,12'h000,1'b0,1'b1,1'b0,1'b0,1'b1},
        {1'b0,3'd0,12'h000,1'b1,12'h0FF,12'h000,1'b0,1'b0,1'b0,1'b0,1'b1},
        {1'b1,3'd2,12'h000,1'b0,12'h000,12'h03C,1'b0,1'b0,1'b0,1'b0,1'b0},
        {1'b1,3'd0,12'hABC,1'b0,12'h000,12'hABC,1'b0,1'b0,1'b1,1'b0,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iop_valid = 1'b0;
    logic [2:0]  iop_code = '0;
    logic [11:0] acc_in = '0;
    logic [11:0] acc_out;
    logic        skip, illegal, punch_ie_set, fetch_req, irq;
    logic        punch_ie_clr = 1'b0;
    logic        chr_valid = 1'b0;
    logic [11:0] chr_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tape_rdr_ctrl u_tape_rdr_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .iop_valid    (iop_valid),
        .iop_code     (iop_code),
        .acc_in       (acc_in),
        .acc_out      (acc_out),
        .skip         (skip),
        .illegal      (illegal),
        .punch_ie_set (punch_ie_set),
        .punch_ie_clr (punch_ie_clr),
        .fetch_req    (fetch_req),
        .chr_valid    (chr_valid),
        .chr_data     (chr_data),
        .irq          (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [11:0] got, input logic [11:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Drive at the falling edge so no input changes at the active edge.
    task automatic drive(input logic v, input logic [2:0] c, input logic [11:0] a,
                         input logic cv, input logic [11:0] cd, input logic pclr);
        @(negedge clk);
        iop_valid = v; iop_code = c; acc_in = a;
        chr_valid = cv; chr_data = cd; punch_ie_clr = pclr;
        #5;
    endtask

    // Pass the active edge, then clear inputs and let outputs settle.
    task automatic edge_then_idle();
        @(posedge clk);
        #1;
        iop_valid = 1'b0; chr_valid = 1'b0; punch_ie_clr = 1'b0;
        #1;
    endtask

    function automatic string tag_of(input logic v, input logic [2:0] c, input logic cv);
        if (!v) return cv ? "R6/R7" : "R11";
        case (c)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd4: return "R4";
            3'd6: return "R5";
            default: return "R10";
        endcase
    endfunction

    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #6;
        // R9: reset state
        chk("R9", "irq in reset", {11'd0, irq}, 12'd0);
        chk("R9", "fetch_req in reset", {11'd0, fetch_req}, 12'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [VEC_W-1:0] r;
            string t;
            r = VECS[i];
            t = tag_of(r[45], r[44:42], r[29]);
            drive(r[45], r[44:42], r[41:30], r[29], r[28:17], 1'b0);
            chk(t, $sformatf("row %0d acc_out", i), acc_out, r[16:5]);
            chk(t, $sformatf("row %0d skip", i), {11'd0, skip}, {11'd0, r[4]});
            chk(t, $sformatf("row %0d illegal", i), {11'd0, illegal}, {11'd0, r[3]});
            chk(t, $sformatf("row %0d punch_ie_set", i), {11'd0, punch_ie_set}, {11'd0, r[2]});
            edge_then_idle();
            chk(t, $sformatf("row %0d fetch_req", i), {11'd0, fetch_req}, {11'd0, r[1]});
            chk(t, $sformatf("row %0d irq", i), {11'd0, irq}, {11'd0, r[0]});
        end

        // R4: fetch request lasts one cycle only
        drive(1'b1, 3'd4, 12'h000, 1'b0, 12'h000, 1'b0);
        edge_then_idle();
        chk("R4", "fetch pulse high", {11'd0, fetch_req}, 12'd1);
        drive(1'b0, 3'd0, 12'h000, 1'b0, 12'h000, 1'b0);
        edge_then_idle();
        chk("R4", "fetch pulse gone", {11'd0, fetch_req}, 12'd0);

        // R6: arrival coinciding with a read-clear wins
        drive(1'b1, 3'd2, 12'h800, 1'b1, 12'h15A, 1'b0);
        chk("R6", "read before latch", acc_out, 12'h83C);
        edge_then_idle();
        chk("R6", "done set despite clear", {11'd0, irq}, 12'd1);
        drive(1'b1, 3'd2, 12'h000, 1'b0, 12'h000, 1'b0);
        chk("R6", "low byte latched", acc_out, 12'h05A);
        edge_then_idle();

        // R8: punch clear gates irq, done is retained, code 0 restores it
        drive(1'b1, 3'd4, 12'h000, 1'b0, 12'h000, 1'b0);
        edge_then_idle();
        drive(1'b0, 3'd0, 12'h000, 1'b1, 12'h011, 1'b0);
        edge_then_idle();
        drive(1'b0, 3'd0, 12'h000, 1'b0, 12'h000, 1'b1);
        edge_then_idle();
        chk("R8", "irq off after enable clear", {11'd0, irq}, 12'd0);
        drive(1'b1, 3'd1, 12'h000, 1'b0, 12'h000, 1'b0);
        chk("R8", "done kept while disabled", {11'd0, skip}, 12'd1);
        edge_then_idle();
        drive(1'b1, 3'd0, 12'h000, 1'b0, 12'h000, 1'b1);
        edge_then_idle();
        chk("R8", "set wins over clear", {11'd0, irq}, 12'd1);

        // R11: undefined code without valid is not decoded
        drive(1'b0, 3'd3, 12'h246, 1'b0, 12'h000, 1'b0);
        chk("R11", "illegal without valid", {11'd0, illegal}, 12'd0);
        chk("R11", "acc passthrough", acc_out, 12'h246);
        edge_then_idle();

        // R9: reset cancels an outstanding fetch and clears the buffer
        drive(1'b1, 3'd4, 12'h000, 1'b0, 12'h000, 1'b0);
        edge_then_idle();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R9", "irq after reset", {11'd0, irq}, 12'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 3'd0, 12'h000, 1'b1, 12'h0EE, 1'b0);
        edge_then_idle();
        chk("R9", "no fetch outstanding", {11'd0, irq}, 12'd0);
        drive(1'b1, 3'd2, 12'h000, 1'b0, 12'h000, 1'b0);
        chk("R9", "buffer cleared", acc_out, 12'h000);
        edge_then_idle();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule